// File: doc/BRIEF.md
# DRAM Bank Timing Guard with Activate-Window Limiter

This block keeps the timing state of every bank in one DRAM rank and decides, cycle by cycle, which commands are legal. For each bank it holds the currently open row, three down-counters that give the earliest cycle for a column access, a precharge and a new activate, and a count of column accesses made since the row was opened. A rank-wide tracker enforces the minimum spacing between activates and keeps a small ring of recent activate timestamps, so that no more than a set number of activates fall inside any rolling window.

A scheduler reads the three per-bank ready masks and the forced-close requests. It then presents one command per cycle as an operation code, a bank and a row. A legal command updates the bank state at the next clock edge. An illegal command leaves all state untouched and raises a one-cycle error pulse.

Top module: `dram_bank_guard`

## Requirements
- R1: After reset every bank reports the closed-row code (all ones on its `open_rows` slice), `act_rdy` is all ones, `col_rdy`, `pre_rdy` and `close_req` are all zeros, and `cmd_err` is low.
- R2: An accepted activate (`cmd_op` = 2'b01) stores `cmd_row` as the bank's open row from the next cycle. An accepted precharge (`cmd_op` = 2'b11) restores the closed-row code. A row value of all ones is reserved and can never be activated.
- R3: A column command (`cmd_op` = 2'b10) to a bank activated in cycle c is ready from cycle c+TRCD. It is accepted only when `cmd_row` equals the bank's open row.
- R4: A bank activated in cycle c reports `pre_rdy` from cycle c+TRAS while it stays open. A closed bank is never precharge-ready.
- R5: A bank precharged in cycle p reports `act_rdy` no earlier than cycle p+TRP.
- R6: After any activate accepted in cycle c, no bank reports `act_rdy` before cycle c+TRRD.
- R7: At most ACT_LIMIT activates are accepted within any TXAW consecutive cycles. A new activate is ready only once the oldest of the last ACT_LIMIT activates is at least TXAW cycles old.
- R8: Each bank counts column commands since its activate. When the count reaches MAX_ACC, `close_req` rises for that bank and `col_rdy` stays low until the row is closed and reopened.
- R9: A command with `cmd_valid` high that is not legal (operation code 2'b00, target not ready, column row mismatch, or the reserved row on activate) raises `cmd_err` for exactly the next cycle and changes no bank, spacing or window state.
- R10: A legal command, or a cycle with `cmd_valid` low, leaves `cmd_err` low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_op | input | 2 | 01 activate, 10 column, 11 precharge, 00 reserved |
| cmd_bank | input | BANK_W | Target bank |
| cmd_row | input | ROW_W | Row for activate, or row expected open for column |
| act_rdy | output | NUM_BANKS | Per-bank activate ready |
| col_rdy | output | NUM_BANKS | Per-bank column ready |
| pre_rdy | output | NUM_BANKS | Per-bank precharge ready |
| close_req | output | NUM_BANKS | Per-bank forced-close request |
| open_rows | output | NUM_BANKS*ROW_W | Open row of each bank, all ones when closed |
| cmd_err | output | 1 | Pulse one cycle after a rejected command |

## Verification
A behavioural model built from absolute cycle stamps and a queue of activate times is compared with every output on every clock. Four stimulus phases are used. The first sends traffic to a single bank, which isolates the per-bank TRCD/TRAS/TRP timers and the access limit. The second mixes guided legal commands across all banks, which exercises the activate spacing and the window alongside each other. The third is mostly random and reserved codes, which checks that rejected commands leave every output unchanged. The fourth favours back-to-back activates and precharges to keep the rolling window saturated.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_ACT  = 2'b01,
    OP_COL  = 2'b10,
    OP_PRE  = 2'b11
  } bank_op_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/dbg_bank_slot.sv
module dbg_bank_slot #(
  parameter int ROW_W   = 4,
  parameter int TRCD    = 3,
  parameter int TRAS    = 7,
  parameter int TRP     = 3,
  parameter int MAX_ACC = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_go,
  input  logic             col_go,
  input  logic             pre_go,
  input  logic [ROW_W-1:0] act_row,
  output logic [ROW_W-1:0] open_row,
  output logic             is_open,
  output logic             act_ok,
  output logic             col_ok,
  output logic             pre_ok,
  output logic             close_req
);
  localparam int TMAX = dbg_pkg::max3(TRCD, TRAS, TRP);
  localparam int CW   = $clog2(TMAX + 1);
  localparam int AW   = $clog2(MAX_ACC + 1);
  localparam logic [ROW_W-1:0] NO_ROW = '1;
  localparam logic [CW-1:0] RCD_LD = CW'(TRCD - 1);
  localparam logic [CW-1:0] RAS_LD = CW'(TRAS - 1);
  localparam logic [CW-1:0] RP_LD  = CW'(TRP - 1);
  localparam logic [AW-1:0] ACC_MAX = AW'(MAX_ACC);

  logic [ROW_W-1:0] row_q, row_d;
  logic [CW-1:0]    colc_q, colc_d, prec_q, prec_d, actc_q, actc_d;
  logic [AW-1:0]    acc_q, acc_d;
  logic             row_en, tmr_en, acc_en;

  always_comb begin
    row_d = row_q;
    if (act_go)      row_d = act_row;
    else if (pre_go) row_d = NO_ROW;

    colc_d = (colc_q != '0) ? colc_q - 1'b1 : colc_q;
    prec_d = (prec_q != '0) ? prec_q - 1'b1 : prec_q;
    actc_d = (actc_q != '0) ? actc_q - 1'b1 : actc_q;
    if (act_go) begin
      colc_d = RCD_LD;
      prec_d = RAS_LD;
    end
    if (pre_go) actc_d = RP_LD;

    acc_d = acc_q;
    if (act_go)                           acc_d = '0;
    else if (col_go && acc_q != ACC_MAX)  acc_d = acc_q + 1'b1;

    row_en = act_go | pre_go;
    tmr_en = act_go | pre_go | (colc_q != '0) | (prec_q != '0) | (actc_q != '0);
    acc_en = act_go | col_go;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q  <= NO_ROW;
      colc_q <= '0;
      prec_q <= '0;
      actc_q <= '0;
      acc_q  <= '0;
    end else begin
      if (row_en) row_q <= row_d;
      if (tmr_en) begin
        colc_q <= colc_d;
        prec_q <= prec_d;
        actc_q <= actc_d;
      end
      if (acc_en) acc_q <= acc_d;
    end
  end

  assign open_row  = row_q;
  assign is_open   = (row_q != NO_ROW);
  assign act_ok    = !is_open && (actc_q == '0);
  assign col_ok    = is_open && (colc_q == '0) && (acc_q != ACC_MAX);
  assign pre_ok    = is_open && (prec_q == '0);
  assign close_req = is_open && (acc_q == ACC_MAX);
endmodule

// File: rtl/dbg_act_window.sv
module dbg_act_window #(
  parameter int WIN   = 10,
  parameter int DEPTH = 2,
  parameter int TRRD  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_go,
  output logic act_allow
);
  localparam int TS_W = $clog2(WIN + 1) + 1;
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int RW   = $clog2(TRRD + 1);
  localparam logic [TS_W-1:0] WIN_T  = TS_W'(WIN);
  localparam logic [RW-1:0]   RRD_LD = RW'(TRRD - 1);
  localparam logic [PW-1:0]   PTR_LAST = PW'(DEPTH - 1);

  logic [TS_W-1:0] now_q;
  logic [TS_W-1:0] ts_q [DEPTH];
  logic [DEPTH-1:0] vld_q, vld_d, expired;
  logic [PW-1:0]   ptr_q, ptr_d;
  logic [RW-1:0]   rrd_q, rrd_d;
  logic            rrd_en;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [TS_W-1:0] age;
    logic            wr_here;
    assign age        = now_q - ts_q[i];
    assign expired[i] = !vld_q[i] || (age >= WIN_T);
    assign wr_here    = act_go && (ptr_q == PW'(i));

    always_comb begin
      vld_d[i] = vld_q[i];
      if (wr_here)         vld_d[i] = 1'b1;
      else if (expired[i]) vld_d[i] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ts_q[i] <= '0;
      else if (wr_here) ts_q[i] <= now_q;
    end
  end

  always_comb begin
    ptr_d = ptr_q;
    if (act_go) ptr_d = (ptr_q == PTR_LAST) ? '0 : ptr_q + 1'b1;
    rrd_d  = act_go ? RRD_LD : ((rrd_q != '0) ? rrd_q - 1'b1 : rrd_q);
    rrd_en = act_go | (rrd_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      now_q <= '0;
      vld_q <= '0;
      ptr_q <= '0;
      rrd_q <= '0;
    end else begin
      now_q <= now_q + 1'b1;
      vld_q <= vld_d;
      if (act_go) ptr_q <= ptr_d;
      if (rrd_en) rrd_q <= rrd_d;
    end
  end

  assign act_allow = expired[ptr_q] && (rrd_q == '0);
endmodule

// File: rtl/dram_bank_guard.sv
module dram_bank_guard #(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 4,
  parameter int TRCD      = 3,
  parameter int TRAS      = 7,
  parameter int TRP       = 3,
  parameter int TRRD      = 2,
  parameter int TXAW      = 10,
  parameter int ACT_LIMIT = 2,
  parameter int MAX_ACC   = 3,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmd_valid,
  input  logic [1:0]                 cmd_op,
  input  logic [BANK_W-1:0]          cmd_bank,
  input  logic [ROW_W-1:0]           cmd_row,
  output logic [NUM_BANKS-1:0]       act_rdy,
  output logic [NUM_BANKS-1:0]       col_rdy,
  output logic [NUM_BANKS-1:0]       pre_rdy,
  output logic [NUM_BANKS-1:0]       close_req,
  output logic [NUM_BANKS*ROW_W-1:0] open_rows,
  output logic                       cmd_err
);
  import dbg_pkg::*;

  localparam logic [ROW_W-1:0] NO_ROW = '1;

  bank_op_e               op;
  logic [ROW_W-1:0]       row_arr [NUM_BANKS];
  logic [NUM_BANKS-1:0]   bank_act_ok, bank_open;
  logic [NUM_BANKS-1:0]   act_go, col_go, pre_go;
  logic                   win_allow, any_act;
  logic                   legal, issue, err_d;

  assign op = bank_op_e'(cmd_op);

  always_comb begin
    legal = 1'b0;
    unique case (op)
      OP_ACT:  legal = act_rdy[cmd_bank] && (cmd_row != NO_ROW);
      OP_COL:  legal = col_rdy[cmd_bank] && (row_arr[cmd_bank] == cmd_row);
      OP_PRE:  legal = pre_rdy[cmd_bank];
      default: legal = 1'b0;
    endcase
    issue = cmd_valid && legal;
    err_d = cmd_valid && !legal;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit       = issue && (cmd_bank == BANK_W'(b));
    assign act_go[b] = hit && (op == OP_ACT);
    assign col_go[b] = hit && (op == OP_COL);
    assign pre_go[b] = hit && (op == OP_PRE);

    dbg_bank_slot #(
      .ROW_W(ROW_W), .TRCD(TRCD), .TRAS(TRAS), .TRP(TRP), .MAX_ACC(MAX_ACC)
    ) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .act_go    (act_go[b]),
      .col_go    (col_go[b]),
      .pre_go    (pre_go[b]),
      .act_row   (cmd_row),
      .open_row  (row_arr[b]),
      .is_open   (bank_open[b]),
      .act_ok    (bank_act_ok[b]),
      .col_ok    (col_rdy[b]),
      .pre_ok    (pre_rdy[b]),
      .close_req (close_req[b])
    );

    assign open_rows[b*ROW_W +: ROW_W] = row_arr[b];
    assign act_rdy[b] = bank_act_ok[b] && win_allow;
  end

  assign any_act = |act_go;

  dbg_act_window #(
    .WIN(TXAW), .DEPTH(ACT_LIMIT), .TRRD(TRRD)
  ) u_window (
    .clk       (clk),
    .rst_n     (rst_n),
    .act_go    (any_act),
    .act_allow (win_allow)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_err <= 1'b0;
    else        cmd_err <= err_d;
  end
endmodule

// File: rtl/dram_bank_guard_chk.sv
module dram_bank_guard_chk #(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 4,
  parameter int TRRD      = 2,
  parameter int BANK_W    = 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cmd_valid,
  input logic [1:0]                 cmd_op,
  input logic [BANK_W-1:0]          cmd_bank,
  input logic [ROW_W-1:0]           cmd_row,
  input logic [NUM_BANKS-1:0]       act_rdy,
  input logic [NUM_BANKS-1:0]       col_rdy,
  input logic [NUM_BANKS-1:0]       pre_rdy,
  input logic [NUM_BANKS-1:0]       close_req,
  input logic [NUM_BANKS*ROW_W-1:0] open_rows,
  input logic                       cmd_err
);
  logic             act_iss;
  logic [BANK_W-1:0] bank_q;
  logic [ROW_W-1:0]  row_q;

  assign act_iss = cmd_valid && (cmd_op == 2'b01) && act_rdy[cmd_bank] && (cmd_row != '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
      row_q  <= '0;
    end else begin
      bank_q <= cmd_bank;
      row_q  <= cmd_row;
    end
  end

  assert_err_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> $past(cmd_valid));

  assert_act_legal_no_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
    act_iss |=> !cmd_err);

  assert_act_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (TRRD > 1 && act_iss) |=> (act_rdy == '0));

  assert_row_loaded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    act_iss |=> (open_rows[bank_q*ROW_W +: ROW_W] == row_q));

  assert_close_blocks_col_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (close_req & col_rdy) == '0);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
    assert_col_needs_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
      col_rdy[b] |-> (open_rows[b*ROW_W +: ROW_W] != '1));
    assert_pre_needs_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
      pre_rdy[b] |-> (open_rows[b*ROW_W +: ROW_W] != '1));
  end
endmodule

bind dram_bank_guard dram_bank_guard_chk #(
  .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .TRRD(TRRD), .BANK_W(BANK_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_bank(cmd_bank), .cmd_row(cmd_row), .act_rdy(act_rdy), .col_rdy(col_rdy),
  .pre_rdy(pre_rdy), .close_req(close_req), .open_rows(open_rows), .cmd_err(cmd_err)
);

// File: tb/dram_bank_guard_bench.sv
module dram_bank_guard_bench;
  localparam int NB = 4, RW = 4, TRCD = 3, TRAS = 7, TRP = 3, TRRD = 2;
  localparam int TXAW = 10, LIM = 2, MAXA = 3, BW = 2;
  localparam int RMAX = (1 << RW) - 1;

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_valid;
  logic [1:0] cmd_op;
  logic [BW-1:0] cmd_bank;
  logic [RW-1:0] cmd_row;
  logic [NB-1:0] act_rdy, col_rdy, pre_rdy, close_req;
  logic [NB*RW-1:0] open_rows;
  logic cmd_err;

  always #10 clk = ~clk;

  dram_bank_guard #(
    .NUM_BANKS(NB), .ROW_W(RW), .TRCD(TRCD), .TRAS(TRAS), .TRP(TRP),
    .TRRD(TRRD), .TXAW(TXAW), .ACT_LIMIT(LIM), .MAX_ACC(MAXA)
  ) u_dram_bank_guard (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_bank(cmd_bank), .cmd_row(cmd_row), .act_rdy(act_rdy), .col_rdy(col_rdy),
    .pre_rdy(pre_rdy), .close_req(close_req), .open_rows(open_rows), .cmd_err(cmd_err)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  int cyc;
  int m_row [NB];
  int m_act_t [NB];
  int m_pre_t [NB];
  int m_acc [NB];
  int m_last_act;
  int m_q [$];
  bit m_err;

  function automatic bit m_act(int b);
    return m_row[b] < 0 && cyc >= m_pre_t[b] + TRP && cyc >= m_last_act + TRRD &&
           (m_q.size() < LIM || cyc >= m_q[0] + TXAW);
  endfunction
  function automatic bit m_col(int b);
    return m_row[b] >= 0 && cyc >= m_act_t[b] + TRCD && m_acc[b] < MAXA;
  endfunction
  function automatic bit m_pre(int b);
    return m_row[b] >= 0 && cyc >= m_act_t[b] + TRAS;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s cycle %0d: actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  task automatic compare_all();
    logic [NB-1:0] ea, ec, ep, ek;
    logic [NB*RW-1:0] er;
    for (int b = 0; b < NB; b++) begin
      ea[b] = m_act(b);
      ec[b] = m_col(b);
      ep[b] = m_pre(b);
      ek[b] = m_row[b] >= 0 && m_acc[b] == MAXA;
      er[b*RW +: RW] = (m_row[b] < 0) ? RW'(RMAX) : RW'(m_row[b]);
    end
    check("R2 open_rows", 64'(open_rows), 64'(er));
    check("R3 col_rdy", 64'(col_rdy), 64'(ec));
    check("R4 pre_rdy", 64'(pre_rdy), 64'(ep));
    check("R5 R6 R7 act_rdy", 64'(act_rdy), 64'(ea));
    check("R8 close_req", 64'(close_req), 64'(ek));
    check("R9 R10 cmd_err", 64'(cmd_err), 64'(m_err));
  endtask

  task automatic pick(int phase, output bit v, output int op, output int b, output int r);
    int sel;
    sel = $urandom_range(0, 99);
    b = (phase == 0) ? 0 : $urandom_range(0, NB - 1);
    v = 1'b1;
    r = $urandom_range(0, RMAX);
    op = $urandom_range(0, 3);
    if (sel < 10) v = 1'b0;
    else if (sel < ((phase == 2) ? 30 : 70)) begin
      if (m_row[b] < 0) begin
        op = 1; r = $urandom_range(0, RMAX - 1);
      end else if (phase == 3 && m_pre(b)) op = 3;
      else if (m_col(b)) begin
        op = 2; r = m_row[b];
      end else if (m_pre(b)) op = 3;
    end else if (op == 2 && m_row[b] >= 0 && $urandom_range(0, 1) == 1) r = m_row[b];
  endtask

  initial begin
    bit v;
    int op, b, r;
    bit legal;
    rst_n = 1'b0;
    cmd_valid = 1'b0; cmd_op = '0; cmd_bank = '0; cmd_row = '0;
    for (int i = 0; i < NB; i++) begin
      m_row[i] = -1; m_act_t[i] = -1000; m_pre_t[i] = -1000; m_acc[i] = 0;
    end
    m_last_act = -1000;
    m_err = 1'b0;
    cyc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    check("R1 act_rdy", 64'(act_rdy), 64'({NB{1'b1}}));
    check("R1 col_rdy", 64'(col_rdy), 64'(0));
    check("R1 pre_rdy", 64'(pre_rdy), 64'(0));
    check("R1 close_req", 64'(close_req), 64'(0));
    check("R1 open_rows", 64'(open_rows), 64'({NB*RW{1'b1}}));
    check("R1 cmd_err", 64'(cmd_err), 64'(0));
    for (int phase = 0; phase < 4; phase++) begin
      for (int k = 0; k < 1500; k++) begin
        compare_all();
        pick(phase, v, op, b, r);
        case (op)
          1: legal = m_act(b) && r != RMAX;
          2: legal = m_col(b) && r == m_row[b];
          3: legal = m_pre(b);
          default: legal = 1'b0;
        endcase
        m_err = v && !legal;
        if (v && legal) begin
          if (op == 1) begin
            m_row[b] = r; m_act_t[b] = cyc; m_acc[b] = 0; m_last_act = cyc;
            m_q.push_back(cyc);
            if (m_q.size() > LIM) void'(m_q.pop_front());
          end else if (op == 2) m_acc[b]++;
          else begin
            m_row[b] = -1; m_pre_t[b] = cyc;
          end
        end
        cmd_valid = v; cmd_op = 2'(op); cmd_bank = BW'(b); cmd_row = RW'(r);
        @(negedge clk);
        cyc++;
      end
    end
    compare_all();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule